// File: doc/BRIEF.md
# Congestion-Aware Odd-Even Path Selector

This block is the route computation stage of one router in a two-dimensional mesh. For each request it takes the router's own coordinates, the coordinates of a destination, and the demand counts that the five input buffers of every router inside a 5x5 window around this router place on each of that router's four output channels. It returns the output direction for the next hop, together with the total congestion of the path behind that choice.

A destination far away is pulled onto the edge of the window, so that it becomes a virtual destination at most two hops away in each dimension. Every minimal path to that point is listed (at most six, each up to four hops), paths that make a turn forbidden by the odd-even turn model are removed, and the congestion of each remaining path is summed hop by hop. The path with the smallest sum wins, and its first hop is the answer. A request addressed to the router itself returns the local port at once.

The result is registered: a request presented with `req_valid` in one cycle appears on the outputs after the next rising clock edge.

Top module: `oe_path_selector`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_dir` is 0 and `rsp_cost` is 0; `rsp_valid` is high in exactly the cycles that follow a rising edge at which `req_valid` was high.
- R2: When the destination equals the current router, `rsp_dir` is 0 (local) and `rsp_cost` is 0.
- R3: The congestion of a channel is the sum of its five 4-bit demand fields; the field for window column wx (0..4, west to east, router at 2), row wy (0..4, south to north, router at 2), channel c (0 north, 1 east, 2 south, 3 west) and input buffer i (0..4) sits at bits [4*k+3:4*k] of `demand`, with k = ((wy*5 + wx)*4 + c)*5 + i.
- R4: The cost of a path is the sum of the congestion of the channel each hop uses, taken as the output channel of the router the hop leaves.
- R5: The x and y offsets from the current router to the destination are each limited to the range -2..+2 before any path is formed; east is increasing x, north increasing y.
- R6: Only minimal paths are formed: the reported direction always reduces the distance to the destination, and a destination on the same row or column gives the straight direction. Codes: 1 north, 2 east, 3 south, 4 west.
- R7: A path is discarded if, at a router in an even absolute column, it turns from east to north or south, or if, at a router in an odd absolute column, it turns from north or south to west.
- R8: The legal path with the lowest cost is chosen; on equal cost the path with the lowest index wins, the index being the number whose bit k is 1 when hop k moves vertically.
- R9: Path costs never wrap: with every demand field at 15 a four-hop path reports 300 on the 9-bit `rsp_cost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A route request is presented this cycle |
| cur_x | input | 5 | Column of this router |
| cur_y | input | 5 | Row of this router |
| dst_x | input | 5 | Column of the destination |
| dst_y | input | 5 | Row of the destination |
| demand | input | 2000 | Demand fields of every window channel, layout in R3 |
| rsp_valid | output | 1 | Result of the previous cycle's request is present |
| rsp_dir | output | 3 | Chosen first-hop direction code |
| rsp_cost | output | 9 | Congestion sum of the chosen path |

## Verification
Every result of this block (direction, cost and valid) is due one rising edge after the request, since the path search is combinational and only the output register lies between request and response. The bench drives each request on a falling edge, lets exactly one rising edge pass and samples a nanosecond later, then drops the request, so each comparison sees the response to that single request and no other. One idle cycle is also sampled to confirm that the valid flag falls when no request was given.

// File: rtl/oe_rc_pkg.sv
package oe_rc_pkg;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  // Output channel slot of a move direction within one router's group of four.
  function automatic int chan_slot(dir_e d);
    case (d)
      DIR_NORTH: return 0;
      DIR_EAST:  return 1;
      DIR_SOUTH: return 2;
      default:   return 3;
    endcase
  endfunction

  // Limit a signed offset to the window radius.
  function automatic int clamp_off(int v, int r);
    if (v > r)  return r;
    if (v < -r) return -r;
    return v;
  endfunction

  // Odd-even rule for a turn taken at a router whose absolute column is odd or even.
  function automatic logic turn_ok(dir_e prev, dir_e nxt, logic col_odd);
    if (prev == DIR_EAST && (nxt == DIR_NORTH || nxt == DIR_SOUTH) && !col_odd)
      return 1'b0;
    if ((prev == DIR_NORTH || prev == DIR_SOUTH) && nxt == DIR_WEST && col_odd)
      return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/rc_offset_clamp.sv
module rc_offset_clamp #(
  parameter int CW = 5,
  parameter int R  = 2,
  parameter int OW = 3
) (
  input  logic [CW-1:0]        cur_x,
  input  logic [CW-1:0]        cur_y,
  input  logic [CW-1:0]        dst_x,
  input  logic [CW-1:0]        dst_y,
  output logic signed [OW-1:0] off_x,
  output logic signed [OW-1:0] off_y,
  output logic                 is_local
);
  import oe_rc_pkg::*;

  always_comb begin
    int dx;
    int dy;
    dx = int'(dst_x) - int'(cur_x);
    dy = int'(dst_y) - int'(cur_y);
    is_local = (dx == 0) && (dy == 0);
    off_x = OW'(clamp_off(dx, R));
    off_y = OW'(clamp_off(dy, R));
  end

endmodule

// File: rtl/rc_channel_congestion.sv
module rc_channel_congestion #(
  parameter int DW  = 4,
  parameter int NIN = 5,
  parameter int NCH = 100,
  parameter int CCW = 7
) (
  input  logic [NCH*NIN*DW-1:0]      demand,
  output logic [NCH-1:0][CCW-1:0]    cong
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_comb begin
      logic [CCW-1:0] acc;
      acc = '0;
      for (int i = 0; i < NIN; i++) begin
        acc = acc + CCW'(demand[(ch*NIN + i)*DW +: DW]);
      end
      cong[ch] = acc;
    end
  end

endmodule

// File: rtl/rc_path_eval.sv
module rc_path_eval #(
  parameter int              R    = 2,
  parameter int              OW   = 3,
  parameter int              NCH  = 100,
  parameter int              CCW  = 7,
  parameter int              PW   = 9,
  parameter int              HOPS = 4,
  parameter logic [HOPS-1:0] MASK = '0
) (
  input  logic signed [OW-1:0]     off_x,
  input  logic signed [OW-1:0]     off_y,
  input  logic                     col0_odd,
  input  logic [NCH-1:0][CCW-1:0]  cong,
  output logic                     legal,
  output logic [PW-1:0]            cost,
  output logic [2:0]               first_dir
);
  import oe_rc_pkg::*;

  localparam int SIDE = 2*R + 1;
  localparam int IW   = $clog2(NCH);

  always_comb begin
    int ax;
    int ay;
    int len;
    int px;
    int py;
    int vcnt;
    logic ok;
    logic [PW-1:0] acc;
    logic [IW-1:0] idx;
    dir_e d;
    dir_e prev;
    dir_e first;
    ax   = (off_x < 0) ? -int'(off_x) : int'(off_x);
    ay   = (off_y < 0) ? -int'(off_y) : int'(off_y);
    len  = ax + ay;
    px   = 0;
    py   = 0;
    vcnt = 0;
    ok   = 1'b1;
    acc  = '0;
    prev  = DIR_LOCAL;
    first = DIR_LOCAL;
    for (int k = 0; k < HOPS; k++) begin
      if (k < len) begin
        if (MASK[k]) begin
          d = (off_y > 0) ? DIR_NORTH : DIR_SOUTH;
          vcnt = vcnt + 1;
        end else begin
          d = (off_x > 0) ? DIR_EAST : DIR_WEST;
        end
        if (k > 0 && !turn_ok(prev, d, col0_odd ^ ((px % 2) != 0)))
          ok = 1'b0;
        idx = IW'(((py + R)*SIDE + (px + R))*4 + chan_slot(d));
        acc = acc + PW'(cong[idx]);
        if (k == 0) first = d;
        case (d)
          DIR_NORTH: py = py + 1;
          DIR_SOUTH: py = py - 1;
          DIR_EAST:  px = px + 1;
          default:   px = px - 1;
        endcase
        prev = d;
      end else if (MASK[k]) begin
        ok = 1'b0;
      end
    end
    legal     = ok && (vcnt == ay) && (len > 0);
    cost      = acc;
    first_dir = first;
  end

endmodule

// File: rtl/rc_min_select.sv
module rc_min_select #(
  parameter int NP = 16,
  parameter int PW = 9
) (
  input  logic [NP-1:0]          legal,
  input  logic [NP-1:0][PW-1:0]  costs,
  input  logic [NP-1:0][2:0]     dirs,
  output logic                   found,
  output logic [PW-1:0]          best_cost,
  output logic [2:0]             best_dir
);

  // Ascending scan with strict compare: the lowest index keeps a tie.
  always_comb begin
    found     = 1'b0;
    best_cost = '0;
    best_dir  = '0;
    for (int i = 0; i < NP; i++) begin
      if (legal[i] && (!found || costs[i] < best_cost)) begin
        found     = 1'b1;
        best_cost = costs[i];
        best_dir  = dirs[i];
      end
    end
  end

endmodule

// File: rtl/oe_path_selector.sv
module oe_path_selector #(
  parameter  int CW   = 5,
  parameter  int DW   = 4,
  parameter  int NIN  = 5,
  parameter  int R    = 2,
  localparam int SIDE = 2*R + 1,
  localparam int NCH  = SIDE*SIDE*4,
  localparam int HOPS = 2*R,
  localparam int NP   = 1 << HOPS,
  localparam int CCW  = DW + $clog2(NIN),
  localparam int PW   = CCW + $clog2(HOPS),
  localparam int OW   = $clog2(R) + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [CW-1:0]         cur_x,
  input  logic [CW-1:0]         cur_y,
  input  logic [CW-1:0]         dst_x,
  input  logic [CW-1:0]         dst_y,
  input  logic [NCH*NIN*DW-1:0] demand,
  output logic                  rsp_valid,
  output logic [2:0]            rsp_dir,
  output logic [PW-1:0]         rsp_cost
);
  import oe_rc_pkg::*;

  logic signed [OW-1:0]     off_x;
  logic signed [OW-1:0]     off_y;
  logic                     is_local;
  logic [NCH-1:0][CCW-1:0]  cong;
  logic [NP-1:0]            legal_vec;
  logic [NP-1:0][PW-1:0]    cost_arr;
  logic [NP-1:0][2:0]       dir_arr;
  logic                     sel_found;
  logic [PW-1:0]            sel_cost;
  logic [2:0]               sel_dir;

  rc_offset_clamp #(.CW(CW), .R(R), .OW(OW)) u_clamp (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .off_x(off_x), .off_y(off_y), .is_local(is_local)
  );

  rc_channel_congestion #(.DW(DW), .NIN(NIN), .NCH(NCH), .CCW(CCW)) u_cong (
    .demand(demand), .cong(cong)
  );

  for (genvar p = 0; p < NP; p++) begin : g_path
    rc_path_eval #(
      .R(R), .OW(OW), .NCH(NCH), .CCW(CCW), .PW(PW), .HOPS(HOPS),
      .MASK(HOPS'(p))
    ) u_eval (
      .off_x(off_x), .off_y(off_y), .col0_odd(cur_x[0]), .cong(cong),
      .legal(legal_vec[p]), .cost(cost_arr[p]), .first_dir(dir_arr[p])
    );
  end

  rc_min_select #(.NP(NP), .PW(PW)) u_select (
    .legal(legal_vec), .costs(cost_arr), .dirs(dir_arr),
    .found(sel_found), .best_cost(sel_cost), .best_dir(sel_dir)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_dir   <= DIR_LOCAL;
      rsp_cost  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        if (is_local) begin
          rsp_dir  <= DIR_LOCAL;
          rsp_cost <= '0;
        end else begin
          rsp_dir  <= sel_dir;
          rsp_cost <= sel_cost;
        end
      end
    end
  end

endmodule

// File: rtl/oe_path_selector_checker.sv
module oe_path_selector_checker #(
  parameter int CW = 5,
  parameter int NP = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [CW-1:0] cur_x,
  input logic [CW-1:0] cur_y,
  input logic [CW-1:0] dst_x,
  input logic [CW-1:0] dst_y,
  input logic          rsp_valid,
  input logic [2:0]    rsp_dir,
  input logic          is_local,
  input logic          sel_found,
  input logic [NP-1:0] legal_vec
);

  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_self_is_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_x == dst_x && cur_y == dst_y) |=> (rsp_dir == 3'd0));

  assert_eastward_minimal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dst_x > cur_x) |=> (rsp_dir == 3'd1 || rsp_dir == 3'd2 || rsp_dir == 3'd3));

  assert_column_north_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dst_x == cur_x && dst_y > cur_y) |=> (rsp_dir == 3'd1));

  assert_legal_path_exists_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_local) |-> sel_found);

  assert_path_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(legal_vec) <= 6));

endmodule

bind oe_path_selector oe_path_selector_checker #(.CW(CW), .NP(NP)) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
  .rsp_valid(rsp_valid), .rsp_dir(rsp_dir),
  .is_local(is_local), .sel_found(sel_found), .legal_vec(legal_vec)
);

// File: tb/oe_path_selector_bench.sv
`timescale 1ns/1ps
module oe_path_selector_bench;

  localparam int NFIELD = 500;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [4:0]    cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
  logic [1999:0] demand;
  logic          rsp_valid;
  logic [2:0]    rsp_dir;
  logic [8:0]    rsp_cost;

  logic [3:0] dem [NFIELD];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  int got_dir, got_cost;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NFIELD; k++) demand[k*4 +: 4] = dem[k];
  end

  oe_path_selector u_oe_path_selector (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .demand(demand), .rsp_valid(rsp_valid), .rsp_dir(rsp_dir), .rsp_cost(rsp_cost)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int ch_load(int wx, int wy, int c);
    int s = 0;
    for (int i = 0; i < 5; i++) s += int'(dem[((wy*5 + wx)*4 + c)*5 + i]);
    return s;
  endfunction

  function automatic int lim(int v);
    return (v > 2) ? 2 : ((v < -2) ? -2 : v);
  endfunction

  // Reference: channel codes 0 N, 1 E, 2 S, 3 W; direction code = channel + 1.
  function automatic void model(input int cx, input int cy, input int tx, input int ty,
                                output int edir, output int ecost);
    int dx, dy, nv, n, best;
    dx = lim(tx - cx);
    dy = lim(ty - cy);
    edir = 0;
    ecost = 0;
    if (dx == 0 && dy == 0) return;
    nv = (dy < 0) ? -dy : dy;
    n  = ((dx < 0) ? -dx : dx) + nv;
    best = -1;
    for (int m = 0; m < 16; m++) begin
      int vc, px, py, cost, prev, fd, d, vert;
      bit ok, odd;
      if ((m >> n) != 0) continue;
      vc = 0; px = 0; py = 0; cost = 0; prev = -1; fd = 0; ok = 1;
      for (int k = 0; k < n; k++) begin
        vert = (m >> k) & 1;
        d = vert ? ((dy > 0) ? 0 : 2) : ((dx > 0) ? 1 : 3);
        odd = ((cx + px) & 1) != 0;
        if (k > 0) begin
          if (prev == 1 && (d == 0 || d == 2) && !odd) ok = 0;
          if ((prev == 0 || prev == 2) && d == 3 && odd) ok = 0;
        end
        cost += ch_load(px + 2, py + 2, d);
        if (k == 0) fd = d;
        if (d == 0) py++; else if (d == 2) py--; else if (d == 1) px++; else px--;
        prev = d;
        vc += vert;
      end
      if (vc != nv) ok = 0;
      if (ok && (best < 0 || cost < best)) begin
        best = cost;
        edir = fd + 1;
      end
    end
    ecost = best;
  endfunction

  task automatic run_case(string tag, int cx, int cy, int tx, int ty);
    int ed, ec;
    @(negedge clk);
    cur_x = 5'(cx); cur_y = 5'(cy); dst_x = 5'(tx); dst_y = 5'(ty);
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    model(cx, cy, tx, ty, ed, ec);
    got_dir = int'(rsp_dir);
    got_cost = int'(rsp_cost);
    check({tag, " R1 valid"}, int'(rsp_valid), 1);
    check({tag, " dir"}, got_dir, ed);
    check({tag, " cost"}, got_cost, ec);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill_dem(int v);
    for (int k = 0; k < NFIELD; k++) dem[k] = 4'(v);
  endtask

  task automatic rand_dem();
    for (int k = 0; k < NFIELD; k++) dem[k] = 4'($urandom_range(0, 15));
  endtask

  task automatic load_ch(int wx, int wy, int c, int v);
    for (int i = 0; i < 5; i++) dem[((wy*5 + wx)*4 + c)*5 + i] = 4'(v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d0, c0;
    void'($urandom(32'd4242));
    fill_dem(0);
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset valid", int'(rsp_valid), 0);
    check("R1 reset dir", int'(rsp_dir), 0);
    check("R1 reset cost", int'(rsp_cost), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: self-addressed request
    rand_dem();
    run_case("R2 local", 10, 10, 10, 10);
    check("R2 local dir", got_dir, 0);
    check("R2 local cost", got_cost, 0);
    @(posedge clk); #1;
    check("R1 idle valid", int'(rsp_valid), 0);

    // R8: all-zero demand, tie to lowest index (vertical, vertical first)
    fill_dem(0);
    run_case("R8 tie", 2, 2, 4, 4);
    check("R8 tie dir", got_dir, 1);

    // R7: even column, east-then-turn path cheapest but illegal
    load_ch(2, 2, 0, 15);
    load_ch(3, 2, 0, 15);
    run_case("R7 even", 2, 2, 4, 4);
    check("R7 even dir", got_dir, 1);
    check("R7 even cost", got_cost, 75);
    run_case("R7 odd", 3, 2, 5, 4);
    check("R7 odd dir", got_dir, 2);
    check("R7 odd cost", got_cost, 0);

    // R3: five inputs summed on one channel
    fill_dem(0);
    for (int i = 0; i < 5; i++) dem[((2*5 + 2)*4 + 1)*5 + i] = 4'(i + 1);
    run_case("R3 sum", 5, 5, 6, 5);
    check("R3 sum dir", got_dir, 2);
    check("R3 sum cost", got_cost, 15);

    // R4 / R6: straight lines
    rand_dem();
    run_case("R4 north", 5, 5, 5, 6);
    check("R4 north cost", got_cost, ch_load(2, 2, 0));
    run_case("R6 west", 20, 5, 3, 5);
    check("R6 west dir", got_dir, 4);
    check("R5 R6 west cost", got_cost, ch_load(2, 2, 3) + ch_load(1, 2, 3));

    // R5: far destination equals boundary destination
    run_case("R5 far", 0, 0, 31, 31);
    d0 = got_dir; c0 = got_cost;
    run_case("R5 edge", 0, 0, 2, 2);
    check("R5 same dir", got_dir, d0);
    check("R5 same cost", got_cost, c0);

    // R9: saturated demand on a four-hop path
    fill_dem(15);
    run_case("R9 max", 10, 10, 12, 8);
    check("R9 max cost", got_cost, 300);

    // Random mix: R4 R6 R7 R8
    for (int t = 0; t < 400; t++) begin
      int cx, cy, tx, ty;
      if (t % 20 == 0) rand_dem();
      cx = $urandom_range(0, 31);
      cy = $urandom_range(0, 31);
      if (t % 5 == 0) begin
        tx = $urandom_range(0, 31);
        ty = $urandom_range(0, 31);
      end else begin
        tx = cx + $urandom_range(0, 6) - 3;
        ty = cy + $urandom_range(0, 6) - 3;
        tx = (tx < 0) ? 0 : ((tx > 31) ? 31 : tx);
        ty = (ty < 0) ? 0 : ((ty > 31) ? 31 : ty);
      end
      run_case("R4 R6 R7 R8 random", cx, cy, tx, ty);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule